// File: doc/BRIEF.md
# Transmit Gate Controller

This block sits between a packet queue and the command path of a 2.4 GHz low-rate radio. It decides the moment at which the controller may issue the "start transmit" command. After the radio finishes sending a frame, or is switched into receive, it needs a dwell of twelve symbol periods before it hunts for incoming frames again. Its clear-channel pin is only meaningful after eight symbols in receive. The block counts these intervals with a symbol tick that it divides down from the system clock. When the interval has passed, it samples the synchronised clear-channel pin.

If the channel is busy, the block draws a delay of 1 to 32 symbols from a free-running 16-bit LFSR and waits that long before it checks again. A clear channel produces a one-cycle grant. The block then follows the start-of-frame pin through its rise and fall. The fall marks the end of the frame and restarts the guard. A channel that stays busy for too long can mean a receive buffer overflow. After a set number of busy checks in a row, the block raises a flush request and starts the receive dwell again, so that the controller can empty the receive buffer instead of retrying forever.

Top module: `tx_gate_ctl`

## Requirements
- R1: Reset counts as a receive enable. While in reset, and straight after it, `tx_grant`, `flush_req` and `busy` are 0. No grant is given within GUARD_SYMS×CLKS_PER_SYM cycles of reset release.
- R2: No grant occurs earlier than GUARD_SYMS×CLKS_PER_SYM cycles after `sfd_pin` is found low at the end of a frame, or after an `rx_on` pulse. `rx_on` restarts the guard from zero. With a request waiting and the channel clear, the grant follows the end of the guard within a few cycles.
- R3: The clear-channel pin is sampled only after at least CCA_SYMS symbols of receive dwell.
- R4: A grant is given only when the synchronised `cca_pin` was sampled high. No grant occurs while `cca_pin` is low.
- R5: A busy sample loads a backoff of (LFSR bits [4:0]) + 1 symbols, which is 1 to 32. When the backoff ends, the channel is sampled again. Once `cca_pin` returns high, a grant follows within 32 symbols plus a few cycles.
- R6: A `tx_req` pulse that arrives during the guard interval is held pending and is served when the guard ends.
- R7: `tx_grant` is a one-cycle pulse. After a grant, the block waits for `sfd_pin` to go high and then low. A request made during the transmission is not granted before the guard that follows that fall has elapsed.
- R8: After MAX_RETRY busy samples in a row, `flush_req` pulses for one cycle and the retry count clears. The guard restarts, and the request stays pending.
- R9: `busy` is 1 while a request is pending, or from the grant until `sfd_pin` is found low again. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_req | input | 1 | Pulse or level: a packet is queued for sending |
| rx_on | input | 1 | One-cycle pulse: the controller just enabled receive |
| cca_pin | input | 1 | Clear-channel status from the radio (1 = clear), asynchronous |
| sfd_pin | input | 1 | Start-of-frame status from the radio, asynchronous |
| tx_grant | output | 1 | One-cycle permission to issue the transmit command |
| busy | output | 1 | Request pending or transmission in flight |
| flush_req | output | 1 | One-cycle pulse: receive buffer flush is advised |

## Verification
The assertions assume three things about the inputs. The radio raises `sfd_pin` only after a grant, and lowers it again within a bounded time. `rx_on` is an internal command pulse, so it needs no synchronising. `cca_pin` may change at any cycle. The stimulus keeps to these: it drives the frame pin only after it has seen a grant, and holds it high for a short fixed span. It changes the clear-channel pin only between frames, or at planned points inside a guard or backoff window. Every expected grant and flush has a cycle window, and each window's lower bound is placed after the last moment a grant would break the guard or clear-channel rules.

// File: rtl/tx_gate_pkg.sv
package tx_gate_pkg;

  localparam int BO_BITS = 5;
  localparam int BO_W    = BO_BITS + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GUARD,
    ST_CCA,
    ST_BACKOFF,
    ST_GRANT,
    ST_SFD_HI,
    ST_SFD_LO
  } gate_state_e;

  // Galois form of x^16 + x^14 + x^13 + x^11 + 1, shifting right
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    lfsr_step = s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction

  // backoff length in symbols: random low bits plus one, so 1 .. 2**BO_BITS
  function automatic logic [BO_W-1:0] backoff_syms(input logic [BO_BITS-1:0] r);
    backoff_syms = {1'b0, r} + BO_W'(1);
  endfunction

endpackage

// File: rtl/gate_pin_sync.sv
module gate_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gate_sym_timer.sv
module gate_sym_timer #(
  parameter int CLKS_PER_SYM = 1600,
  parameter int GUARD_SYMS   = 12,
  parameter int CCA_SYMS     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic sym_tick,
  output logic guard_met,
  output logic cca_ok
);
  localparam int DIV_W   = (CLKS_PER_SYM > 1) ? $clog2(CLKS_PER_SYM) : 1;
  localparam int SAT     = (GUARD_SYMS > CCA_SYMS) ? GUARD_SYMS : CCA_SYMS;
  localparam int DW_W    = $clog2(SAT + 1);

  logic [DIV_W-1:0] div_q;
  logic [DW_W-1:0]  dwell_q;

  assign sym_tick = (div_q == DIV_W'(CLKS_PER_SYM - 1));

  // divider phase is cleared on restart so the dwell is exact in clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 div_q <= '0;
    else if (restart || sym_tick) div_q <= '0;
    else                        div_q <= div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   dwell_q <= '0;
    else if (restart)                             dwell_q <= '0;
    else if (sym_tick && dwell_q < DW_W'(SAT))    dwell_q <= dwell_q + DW_W'(1);
  end

  assign guard_met = (dwell_q >= DW_W'(GUARD_SYMS));
  assign cca_ok    = (dwell_q >= DW_W'(CCA_SYMS));
endmodule

// File: rtl/gate_backoff_lfsr.sv
module gate_backoff_lfsr
  import tx_gate_pkg::*;
#(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [BO_BITS-1:0] rnd
);
  logic [15:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= lfsr_step(state_q);
  end

  assign rnd = state_q[BO_BITS-1:0];
endmodule

// File: rtl/tx_gate_ctl.sv
module tx_gate_ctl
  import tx_gate_pkg::*;
#(
  parameter int          CLKS_PER_SYM = 1600,
  parameter int          GUARD_SYMS   = 12,
  parameter int          CCA_SYMS     = 8,
  parameter int          MAX_RETRY    = 8,
  parameter int          SYNC_STAGES  = 2,
  parameter logic [15:0] LFSR_SEED    = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_req,
  input  logic rx_on,
  input  logic cca_pin,
  input  logic sfd_pin,
  output logic tx_grant,
  output logic busy,
  output logic flush_req
);
  localparam int RT_W = $clog2(MAX_RETRY + 1);

  gate_state_e state_q, state_d;
  logic [RT_W-1:0]    retry_q, retry_d;
  logic [BO_W-1:0]    bo_q, bo_d, bo_val;
  logic [BO_BITS-1:0] rnd;
  logic pend_q, pend_d, flush_q;
  logic cca_s, sfd_s;
  logic sym_tick, guard_met, cca_ok;
  logic restart, flush_fire, bo_load, rx_hit, want_tx, cca_sample;

  gate_pin_sync #(.STAGES(SYNC_STAGES)) u_cca_sync (
    .clk(clk), .rst_n(rst_n), .d(cca_pin), .q(cca_s));

  gate_pin_sync #(.STAGES(SYNC_STAGES)) u_sfd_sync (
    .clk(clk), .rst_n(rst_n), .d(sfd_pin), .q(sfd_s));

  gate_sym_timer #(
    .CLKS_PER_SYM(CLKS_PER_SYM),
    .GUARD_SYMS  (GUARD_SYMS),
    .CCA_SYMS    (CCA_SYMS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .sym_tick(sym_tick), .guard_met(guard_met), .cca_ok(cca_ok));

  gate_backoff_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .rnd(rnd));

  assign bo_val     = backoff_syms(rnd);
  assign want_tx    = pend_q | tx_req;
  assign cca_sample = (state_q == ST_CCA);
  assign rx_hit     = rx_on && (state_q inside {ST_IDLE, ST_GUARD, ST_CCA, ST_BACKOFF});

  always_comb begin
    state_d    = state_q;
    retry_d    = retry_q;
    bo_d       = bo_q;
    restart    = 1'b0;
    flush_fire = 1'b0;
    bo_load    = 1'b0;
    if (rx_hit) begin
      state_d = ST_GUARD;
      restart = 1'b1;
      retry_d = '0;
    end else begin
      case (state_q)
        ST_IDLE:    if (want_tx && cca_ok) state_d = ST_CCA;
        ST_GUARD:   if (guard_met) state_d = want_tx ? ST_CCA : ST_IDLE;
        ST_CCA: begin
          if (cca_s) begin
            state_d = ST_GRANT;
          end else if (retry_q == RT_W'(MAX_RETRY - 1)) begin
            flush_fire = 1'b1;
            restart    = 1'b1;
            retry_d    = '0;
            state_d    = ST_GUARD;
          end else begin
            bo_load = 1'b1;
            bo_d    = bo_val;
            retry_d = retry_q + RT_W'(1);
            state_d = ST_BACKOFF;
          end
        end
        ST_BACKOFF: begin
          if (sym_tick) begin
            if (bo_q == BO_W'(1)) state_d = ST_CCA;
            else                  bo_d    = bo_q - BO_W'(1);
          end
        end
        ST_GRANT: begin
          retry_d = '0;
          state_d = ST_SFD_HI;
        end
        ST_SFD_HI:  if (sfd_s) state_d = ST_SFD_LO;
        ST_SFD_LO: begin
          if (!sfd_s) begin
            state_d = ST_GUARD;
            restart = 1'b1;
          end
        end
        default:    state_d = ST_GUARD;
      endcase
    end
  end

  assign pend_d = (state_q == ST_GRANT) ? tx_req : (pend_q | tx_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_GUARD;
      retry_q <= '0;
      bo_q    <= BO_W'(1);
      pend_q  <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      state_q <= state_d;
      retry_q <= retry_d;
      bo_q    <= bo_d;
      pend_q  <= pend_d;
      flush_q <= flush_fire;
    end
  end

  assign tx_grant  = (state_q == ST_GRANT);
  assign flush_req = flush_q;
  assign busy      = pend_q | (state_q inside {ST_GRANT, ST_SFD_HI, ST_SFD_LO});
endmodule

// File: rtl/tx_gate_checker.sv
module tx_gate_checker
  import tx_gate_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            tx_grant,
  input logic            flush_req,
  input logic            busy,
  input logic            guard_met,
  input logic            cca_ok,
  input logic            cca_sample,
  input logic            cca_s,
  input logic            bo_load,
  input logic [BO_W-1:0] bo_val
);
  assert_guard_before_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |-> guard_met);

  assert_cca_dwell_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cca_sample |-> cca_ok);

  assert_clear_before_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |-> $past(cca_sample && cca_s));

  assert_backoff_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bo_load |-> (bo_val >= BO_W'(1) && bo_val <= BO_W'(32)));

  assert_grant_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |=> !tx_grant);

  assert_flush_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req);

  assert_flush_not_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !tx_grant);

  assert_busy_after_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |=> busy);
endmodule

bind tx_gate_ctl tx_gate_checker u_gate_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_grant  (tx_grant),
  .flush_req (flush_req),
  .busy      (busy),
  .guard_met (guard_met),
  .cca_ok    (cca_ok),
  .cca_sample(cca_sample),
  .cca_s     (cca_s),
  .bo_load   (bo_load),
  .bo_val    (bo_val)
);

// File: tb/tx_gate_ctl_bench.sv
module tx_gate_ctl_bench;
  localparam int CPS       = 4;
  localparam int GSYM      = 12;
  localparam int CSYM      = 8;
  localparam int MAXR      = 8;
  localparam int GUARD_CYC = GSYM * CPS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_req = 1'b0, rx_on = 1'b0, cca_pin = 1'b1, sfd_pin = 1'b0;
  wire  tx_grant, busy, flush_req;

  always #5 clk = ~clk;

  tx_gate_ctl #(
    .CLKS_PER_SYM(CPS), .GUARD_SYMS(GSYM), .CCA_SYMS(CSYM), .MAX_RETRY(MAXR)
  ) u_tx_gate_ctl (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .rx_on(rx_on),
    .cca_pin(cca_pin), .sfd_pin(sfd_pin),
    .tx_grant(tx_grant), .busy(busy), .flush_req(flush_req));

  typedef struct {
    bit    is_flush;
    int    lo;
    int    hi;
    string tag;
  } exp_t;

  exp_t expq[$];
  int cyc = 0, checks = 0, errors = 0;
  int grants_seen = 0, flushes_seen = 0, last_evt_cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic expect_evt(input bit fl, input int lo, input int hi, input string tag);
    exp_t e;
    e.is_flush = fl; e.lo = lo; e.hi = hi; e.tag = tag;
    expq.push_back(e);
  endtask

  // monitor: pop one expectation per observed grant or flush
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && (tx_grant || flush_req)) begin
      if (expq.size() == 0) begin
        check(1'b0, flush_req ? "R8" : "R4", "unexpected event at cycle", cyc, -1);
      end else begin
        e = expq.pop_front();
        check(e.is_flush == flush_req, e.tag, "event kind (1=flush)", flush_req, e.is_flush);
        check(cyc >= e.lo && cyc <= e.hi, e.tag, "event cycle vs window low", cyc, e.lo);
        if (cyc > e.hi) $display("  window high was %0d", e.hi);
      end
      if (tx_grant)  grants_seen++;
      if (flush_req) flushes_seen++;
      last_evt_cyc = cyc;
    end
  end

  task automatic pulse_req();
    @(negedge clk) tx_req = 1'b1;
    @(negedge clk) tx_req = 1'b0;
  endtask

  // wait for grant number n, then play a frame on sfd_pin; returns fall cycle
  task automatic frame(input int n, input bit req_mid, input bit cca_low, output int fall);
    wait (grants_seen >= n);
    @(negedge clk) sfd_pin = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R9", "busy during frame", busy, 1);
    if (cca_low) cca_pin = 1'b0;
    if (req_mid) pulse_req();
    repeat (6) @(negedge clk);
    sfd_pin = 1'b0;
    fall = cyc;
  endtask

  initial begin
    int r, f, fl;
    repeat (4) @(negedge clk);
    check(tx_grant == 1'b0, "R1", "grant in reset", tx_grant, 0);
    check(busy == 1'b0, "R1", "busy in reset", busy, 0);
    check(flush_req == 1'b0, "R1", "flush in reset", flush_req, 0);

    // T1: request right after reset; guard (R1) and clear-channel dwell (R3)
    @(negedge clk) rst_n = 1'b1;
    r = cyc;
    tx_req = 1'b1;
    expect_evt(1'b0, r + GUARD_CYC, r + GUARD_CYC + 12, "R1 R3");
    @(negedge clk) tx_req = 1'b0;
    check(busy == 1'b1, "R9", "busy with pending request", busy, 1);

    // T2: request during transmission waits for fall plus guard (R7)
    frame(1, 1'b1, 1'b0, f);
    expect_evt(1'b0, f + GUARD_CYC, f + GUARD_CYC + 12, "R7");

    // T3: request arriving inside the guard is held (R6)
    frame(2, 1'b0, 1'b0, f);
    repeat (5) @(negedge clk);
    check(busy == 1'b0, "R9", "busy after frame, no request", busy, 0);
    repeat (5) @(negedge clk);
    expect_evt(1'b0, f + GUARD_CYC, f + GUARD_CYC + 12, "R6");
    pulse_req();

    // T4: idle, then rx_on restarts the guard (R2)
    frame(3, 1'b0, 1'b0, f);
    repeat (80) @(negedge clk);
    check(busy == 1'b0, "R9", "busy idle", busy, 0);
    @(negedge clk);
    r = cyc;
    rx_on = 1'b1; tx_req = 1'b1;
    expect_evt(1'b0, r + GUARD_CYC, r + GUARD_CYC + 12, "R2");
    @(negedge clk) begin rx_on = 1'b0; tx_req = 1'b0; end

    // T5: busy channel past the guard, then clear: backoff and recheck (R4 R5)
    frame(4, 1'b1, 1'b1, f);
    repeat (60) @(negedge clk);
    r = cyc;
    cca_pin = 1'b1;
    expect_evt(1'b0, r + 1, r + 32 * CPS + 40, "R4 R5");

    // T6: channel never clear: flush after MAXR busy samples (R8)
    frame(5, 1'b1, 1'b1, f);
    expect_evt(1'b1, f + GUARD_CYC, f + GUARD_CYC + MAXR * (33 * CPS + 4) + 20, "R8");
    repeat (GUARD_CYC + 20) @(negedge clk);
    check(busy == 1'b1, "R9", "busy while backing off", busy, 1);
    wait (flushes_seen >= 1);
    fl = last_evt_cyc;
    expect_evt(1'b0, fl + GUARD_CYC - 1, fl + GUARD_CYC + 12, "R8");
    @(negedge clk) cca_pin = 1'b1;
    frame(6, 1'b0, 1'b0, f);
    repeat (GUARD_CYC + 30) @(negedge clk);

    check(expq.size() == 0, "R2", "expectations left over", expq.size(), 0);
    check(grants_seen == 6, "R7", "grant count", grants_seen, 6);
    check(flushes_seen == 1, "R8", "flush count", flushes_seen, 1);
    check(busy == 1'b0, "R9", "busy at end", busy, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule